// File: doc/BRIEF.md
# Deep-Sleep Exit Reset Sequencer

This block governs the boundary of the deepest power-off state. When software asks for deep sleep, it freezes every pad's output value and direction into hold latches and drives the pads from them. The system reset is held active for the whole of the sleep. Two things end the sleep: a wake-up event or the external reset pin. Either one starts a reset sequence that keeps the system reset asserted for a programmable minimum number of cycles. The block records why that reset happened in two sticky flags, one for the pin and one for wake-up.

After recovery the pads stay frozen until software writes an isolation-acknowledge bit. This gives firmware time to restore the port configuration before the pads go back to live control. A debug hold bit is kept in an always-on register and survives sleep. While it is set, the next recovery from sleep stretches the system reset until the debugger clears the bit.

Register port (one address bit):
- Address 0, control:
  - Bit 0 reads as the isolation state; writing 1 to it is the acknowledge.
  - Bit 1 is the debug hold bit, read/write.
- Address 1, status (read-only):
  - Bit 0 is the pin flag.
  - Bit 1 is the wake flag.

Top module: `deep_sleep_exit_seq`

## Requirements
- R1: After power-on reset, sysRstN is 1, isolation is off, both status flags and the debug hold bit read 0, and padOut/padDir follow padOutLive/padDirLive.
- R2: A sleepReq sampled in run (with rstPinN high) enters sleep. It captures padOutLive/padDirLive into the latches, and the pads keep those values whatever the live inputs do. sysRstN is 0 throughout the sleep.
- R3: A wakeEvt sampled in sleep starts the exit sequence. sysRstN is 0 for exactly RST_CYC cycles after that edge and then returns to 1. Status reads 2'b10 (wake flag bit 1 set, pin flag bit 0 clear).
- R4: rstPinN low sampled in sleep exits the same way and sets both flags: status reads 2'b11.
- R5: rstPinN low sampled in run starts a reset sequence that sets only the pin flag (status 2'b01) and leaves the isolation state unchanged.
- R6: While rstPinN is low, sysRstN stays 0. sysRstN returns to 1 exactly RST_CYC cycles after the last edge at which the pin was sampled low.
- R7: Isolation stays in force after the exit until a write of 1 to control bit 0 while sysRstN is 1. The pads then follow the live inputs.
- R8: An acknowledge written while sysRstN is 0 is ignored (isolation stays 1). An acknowledge written while not isolated has no effect (isolation stays 0, and the next sleep still isolates).
- R9: With the debug hold bit (control bit 1) set, sysRstN stays 0 after a sleep exit until the bit is cleared. The bit keeps its value through sleep.
- R10: The debug hold bit does not stretch a reset started from run by the pin: sysRstN still returns after RST_CYC cycles.
- R11: The status flags keep their value through sleep entry and normal operation until the next reset sequence overwrites them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| sleepReq | input | 1 | Request to enter deep sleep |
| wakeEvt | input | 1 | Wake-up event |
| rstPinN | input | 1 | External reset pin, active low |
| padOutLive | input | NPAD | Live pad output values from the port logic |
| padDirLive | input | NPAD | Live pad direction values from the port logic |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register address (0 control, 1 status) |
| regWrData | input | REG_W | Register write data |
| regRdData | output | REG_W | Register read data |
| padOut | output | NPAD | Pad output value driven to the pads |
| padDir | output | NPAD | Pad direction driven to the pads |
| isoActive | output | 1 | Pad isolation in force |
| sysRstN | output | 1 | System reset, active low |

## Verification
The exit sequence is tried with each trigger: a wake event, a reset pin pulse during sleep, and a reset pin pulse and a long held pin during run. The flag codes 2'b10, 2'b11 and 2'b01 tell the triggers apart, and the measured reset length separates the fixed minimum from the pin-extended case. The pads are given patterns that change after capture, which shows whether the pads come from the latches or the live inputs. Acknowledge writes are placed during reset, while not isolated and in run, to separate accepted from ignored writes. The debug hold bit is tried on both a sleep exit and a run pin reset, which shows that it stretches only the former.

// File: rtl/dsx_pkg.sv
package dsx_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_EXIT, ST_DBGHOLD} seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       captureEn;
    logic       flagLoad;
    logic [1:0] flagVal;
    logic       ackAllowed;
  } seqStrobe_t;

  localparam int FLAG_PIN  = 0;
  localparam int FLAG_WAKE = 1;
endpackage

// File: rtl/dsx_ctrl.sv
module dsx_ctrl
  import dsx_pkg::*;
#(
  parameter int RST_CYC = 16
) (
  input  logic       clk,
  input  logic       porRstN,
  input  logic       sleepReq,
  input  logic       wakeEvt,
  input  logic       rstPinN,
  input  logic       dbgHold,
  output seqStrobe_t strobe,
  output logic       sysRstN
);
  localparam int CNT_W = $clog2(RST_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYC - 1);

  seqState_t        state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic             fromSleep, fromSleepNxt;

  always_comb begin
    stateNxt     = state;
    cntNxt       = cnt;
    fromSleepNxt = fromSleep;
    strobe       = '0;
    case (state)
      ST_RUN: begin
        strobe.ackAllowed = 1'b1;
        if (!rstPinN) begin
          stateNxt        = ST_EXIT;
          cntNxt          = CNT_LOAD;
          fromSleepNxt    = 1'b0;
          strobe.flagLoad = 1'b1;
          strobe.flagVal  = 2'b01;
        end else if (sleepReq) begin
          stateNxt         = ST_SLEEP;
          strobe.captureEn = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (!rstPinN || wakeEvt) begin
          stateNxt        = ST_EXIT;
          cntNxt          = CNT_LOAD;
          fromSleepNxt    = 1'b1;
          strobe.flagLoad = 1'b1;
          strobe.flagVal[FLAG_WAKE] = 1'b1;
          strobe.flagVal[FLAG_PIN]  = !rstPinN;
        end
      end
      ST_EXIT: begin
        if (!rstPinN) cntNxt = CNT_LOAD;
        else if (cnt == '0) stateNxt = (fromSleep && dbgHold) ? ST_DBGHOLD : ST_RUN;
        else cntNxt = cnt - 1'b1;
      end
      default: begin
        if (!rstPinN) begin
          stateNxt = ST_EXIT;
          cntNxt   = CNT_LOAD;
        end else if (!dbgHold) begin
          stateNxt = ST_RUN;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      state     <= ST_RUN;
      cnt       <= '0;
      fromSleep <= 1'b0;
    end else begin
      state     <= stateNxt;
      cnt       <= cntNxt;
      fromSleep <= fromSleepNxt;
    end
  end

  assign sysRstN = (state == ST_RUN);

  AST_PIN_HOLDS_RST: assert property (@(posedge clk) disable iff (!porRstN)
    !rstPinN |=> !sysRstN); // R6
  AST_SLEEP_KEEPS_RST: assert property (@(posedge clk) disable iff (!porRstN)
    (state == ST_SLEEP && rstPinN && !wakeEvt) |=> !sysRstN); // R2
  AST_DBG_STRETCH: assert property (@(posedge clk) disable iff (!porRstN)
    (state == ST_DBGHOLD && dbgHold) |=> !sysRstN); // R9
  AST_EXIT_NEEDS_TRIGGER: assert property (@(posedge clk) disable iff (!porRstN)
    ($past(state) == ST_SLEEP && state == ST_EXIT) |-> ($past(wakeEvt) || !$past(rstPinN))); // R3
endmodule

// File: rtl/dsx_datapath.sv
module dsx_datapath
  import dsx_pkg::*;
#(
  parameter int NPAD  = 8,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             porRstN,
  input  seqStrobe_t       strobe,
  input  logic [NPAD-1:0]  padOutLive,
  input  logic [NPAD-1:0]  padDirLive,
  input  logic             regWrEn,
  input  logic             regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic [NPAD-1:0]  padOut,
  output logic [NPAD-1:0]  padDir,
  output logic             isoActive,
  output logic             dbgHold
);
  logic       iso;
  logic [1:0] flags;
  logic       ackWrite;
  logic       unusedWrBits;

  assign unusedWrBits = ^regWrData[REG_W-1:2];
  assign ackWrite     = regWrEn && !regAddr && regWrData[0];

  // per-pad hold latch and output mux
  for (genvar p = 0; p < NPAD; p++) begin : g_pad
    logic latOut, latDir;
    always_ff @(posedge clk or negedge porRstN) begin
      if (!porRstN) begin
        latOut <= 1'b0;
        latDir <= 1'b0;
      end else if (strobe.captureEn) begin
        latOut <= padOutLive[p];
        latDir <= padDirLive[p];
      end
    end
    assign padOut[p] = iso ? latOut : padOutLive[p];
    assign padDir[p] = iso ? latDir : padDirLive[p];
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      iso     <= 1'b0;
      flags   <= '0;
      dbgHold <= 1'b0;
    end else begin
      if (strobe.captureEn) iso <= 1'b1;
      else if (strobe.ackAllowed && ackWrite) iso <= 1'b0;
      if (strobe.flagLoad) flags <= strobe.flagVal;
      if (regWrEn && !regAddr) dbgHold <= regWrData[1];
    end
  end

  assign isoActive = iso;

  always_comb begin
    regRdData = '0;
    if (!regAddr) begin
      regRdData[0] = iso;
      regRdData[1] = dbgHold;
    end else begin
      regRdData[1:0] = flags;
    end
  end

  AST_ISO_STICKY: assert property (@(posedge clk) disable iff (!porRstN)
    (iso && !(strobe.ackAllowed && ackWrite)) |=> iso); // R7
  AST_ACK_GATED: assert property (@(posedge clk) disable iff (!porRstN)
    $fell(iso) |-> $past(strobe.ackAllowed)); // R8
  AST_PAD_FROZEN: assert property (@(posedge clk) disable iff (!porRstN)
    (iso && $past(iso) && !$past(strobe.captureEn)) |->
      (padOut == $past(padOut) && padDir == $past(padDir))); // R2
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!porRstN)
    !$past(strobe.flagLoad) |-> $stable(flags)); // R11
endmodule

// File: rtl/deep_sleep_exit_seq.sv
module deep_sleep_exit_seq
  import dsx_pkg::*;
#(
  parameter int NPAD    = 8,
  parameter int RST_CYC = 16,
  parameter int REG_W   = 8
) (
  input  logic             clk,
  input  logic             porRstN,
  input  logic             sleepReq,
  input  logic             wakeEvt,
  input  logic             rstPinN,
  input  logic [NPAD-1:0]  padOutLive,
  input  logic [NPAD-1:0]  padDirLive,
  input  logic             regWrEn,
  input  logic             regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic [NPAD-1:0]  padOut,
  output logic [NPAD-1:0]  padDir,
  output logic             isoActive,
  output logic             sysRstN
);
  seqStrobe_t strobe;
  logic       dbgHold;

  dsx_ctrl #(.RST_CYC(RST_CYC)) u_ctrl (
    .clk(clk), .porRstN(porRstN), .sleepReq(sleepReq), .wakeEvt(wakeEvt),
    .rstPinN(rstPinN), .dbgHold(dbgHold), .strobe(strobe), .sysRstN(sysRstN)
  );

  dsx_datapath #(.NPAD(NPAD), .REG_W(REG_W)) u_dp (
    .clk(clk), .porRstN(porRstN), .strobe(strobe),
    .padOutLive(padOutLive), .padDirLive(padDirLive),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .padOut(padOut), .padDir(padDir),
    .isoActive(isoActive), .dbgHold(dbgHold)
  );
endmodule

// File: tb/deep_sleep_exit_seq_bench.sv
module deep_sleep_exit_seq_bench;
  localparam int NPAD = 8;
  localparam int RCYC = 5;
  localparam int RW   = 8;

  logic clk = 1'b0;
  logic porRstN = 1'b0;
  logic sleepReq = 1'b0, wakeEvt = 1'b0, rstPinN = 1'b1;
  logic [NPAD-1:0] padOutLive = '0, padDirLive = '0;
  logic regWrEn = 1'b0, regAddr = 1'b0;
  logic [RW-1:0] regWrData = '0;
  logic [RW-1:0] regRdData;
  logic [NPAD-1:0] padOut, padDir;
  logic isoActive, sysRstN;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  deep_sleep_exit_seq #(.NPAD(NPAD), .RST_CYC(RCYC), .REG_W(RW)) u_deep_sleep_exit_seq (
    .clk(clk), .porRstN(porRstN), .sleepReq(sleepReq), .wakeEvt(wakeEvt),
    .rstPinN(rstPinN), .padOutLive(padOutLive), .padDirLive(padDirLive),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .padOut(padOut), .padDir(padDir),
    .isoActive(isoActive), .sysRstN(sysRstN)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [RW-1:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic a, output logic [RW-1:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  task automatic enter_sleep();
    sleepReq = 1'b1; @(negedge clk); sleepReq = 1'b0;
  endtask

  task automatic wake_count(output int n);
    wakeEvt = 1'b1; @(negedge clk); wakeEvt = 1'b0;
    n = 0;
    while (!sysRstN && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic pin_count(input int hold, output int n);
    rstPinN = 1'b0; n = 0;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (!sysRstN) n++;
    end
    rstPinN = 1'b1;
    while (!sysRstN && n < 1000) begin @(negedge clk); if (!sysRstN) n++; end
  endtask

  task automatic t_reset();
    logic [RW-1:0] d;
    padOutLive = 8'h96; padDirLive = 8'hF0; #1;
    chk(sysRstN == 1'b1, "R1 sysRstN", sysRstN, 1);
    chk(isoActive == 1'b0, "R1 isoActive", isoActive, 0);
    chk(padOut == 8'h96 && padDir == 8'hF0, "R1 pads live", {padOut, padDir}, 16'h96F0);
    rd(1'b1, d); chk(d == 8'h00, "R1 status", d, 0);
    rd(1'b0, d); chk(d == 8'h00, "R1 control", d, 0);
  endtask

  task automatic t_sleep_wake();
    logic [RW-1:0] d; int n;
    padOutLive = 8'hA5; padDirLive = 8'h0F;
    enter_sleep();
    padOutLive = 8'h3C; padDirLive = 8'hC3;
    repeat (3) @(negedge clk);
    chk(isoActive == 1'b1, "R2 isolated", isoActive, 1);
    chk(padOut == 8'hA5 && padDir == 8'h0F, "R2 pads frozen", {padOut, padDir}, 16'hA50F);
    chk(sysRstN == 1'b0, "R2 reset in sleep", sysRstN, 0);
    wake_count(n);
    chk(n == RCYC, "R3 exit length", n, RCYC);
    rd(1'b1, d); chk(d == 8'h02, "R3 wake flags", d, 2);
    chk(padOut == 8'hA5 && isoActive, "R7 pads frozen after exit", padOut, 8'hA5);
  endtask

  task automatic t_ack();
    logic [RW-1:0] d; int n;
    wr(1'b0, 8'h01);
    chk(isoActive == 1'b0, "R7 ack clears iso", isoActive, 0);
    chk(padOut == 8'h3C && padDir == 8'hC3, "R7 pads live", {padOut, padDir}, 16'h3CC3);
    wr(1'b0, 8'h01);
    chk(isoActive == 1'b0, "R8 ack when not isolated", isoActive, 0);
    padOutLive = 8'h5A;
    enter_sleep();
    padOutLive = 8'h00;
    @(negedge clk);
    chk(isoActive && padOut == 8'h5A, "R8 next sleep still isolates", padOut, 8'h5A);
    rstPinN = 1'b0; @(negedge clk); rstPinN = 1'b1;
    wr(1'b0, 8'h01);
    chk(isoActive == 1'b1, "R8 ack during reset ignored", isoActive, 1);
    n = 0;
    while (!sysRstN && n < 1000) begin n++; @(negedge clk); end
    rd(1'b1, d); chk(d == 8'h03, "R4 pin exit flags", d, 3);
    chk(isoActive == 1'b1, "R7 iso after pin exit", isoActive, 1);
    wr(1'b0, 8'h01);
    chk(isoActive == 1'b0, "R7 ack after pin exit", isoActive, 0);
  endtask

  task automatic t_pin_run();
    logic [RW-1:0] d; int n;
    pin_count(1, n);
    chk(n == RCYC, "R5 pin reset length", n, RCYC);
    rd(1'b1, d); chk(d == 8'h01, "R5 pin flags", d, 1);
    chk(isoActive == 1'b0, "R5 iso unchanged", isoActive, 0);
    pin_count(7, n);
    chk(n == 7 + RCYC - 1, "R6 held pin length", n, 7 + RCYC - 1);
  endtask

  task automatic t_dbg();
    logic [RW-1:0] d; int n;
    wr(1'b0, 8'h02);
    pin_count(1, n);
    chk(n == RCYC, "R10 pin reset not stretched", n, RCYC);
    rd(1'b1, d); chk(d == 8'h01, "R11 flags before sleep", d, 1);
    enter_sleep();
    repeat (2) @(negedge clk);
    rd(1'b1, d); chk(d == 8'h01, "R11 flags kept in sleep", d, 1);
    wakeEvt = 1'b1; @(negedge clk); wakeEvt = 1'b0;
    repeat (RCYC + 10) @(negedge clk);
    chk(sysRstN == 1'b0, "R9 reset stretched", sysRstN, 0);
    rd(1'b0, d); chk(d[1] == 1'b1, "R9 debug bit kept", d[1], 1);
    wr(1'b0, 8'h00);
    @(negedge clk);
    chk(sysRstN == 1'b1, "R9 release on clear", sysRstN, 1);
    rd(1'b1, d); chk(d == 8'h02, "R11 flags after wake", d, 2);
    wr(1'b0, 8'h01);
    chk(isoActive == 1'b0, "R7 final ack", isoActive, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    porRstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_sleep_wake();
    t_ack();
    t_pin_run();
    t_dbg();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule